// File: doc/BRIEF.md
# Source-Routed Burst Crossbar

This block is a non-blocking crossbar switch with a parameterized number of full-duplex ports. Each port carries words made of a data field, a one-bit tail flag and a four-bit route field. A sender starts a burst by putting the number of the wanted destination port in the route field of its first word. It then streams words of any count until it sends a word with the tail flag set. On the way out, the switch overwrites the route field with the number of the input port the burst came from. The receiver therefore always knows the origin of each word.

Each output port has its own round-robin arbiter. Once an input wins an output, that input keeps the output until its tail word has been taken. Inputs and outputs use valid/ready handshakes. The data path holds no registers, so a receiver that stalls stalls the matching sender in the same cycle. Pairs of inputs and outputs that do not share a port move data at the same time without affecting each other.

A burst whose first word names a port that does not exist is taken in and thrown away, up to and including its tail. A sticky error flag records that this happened.

Top module: `burst_xbar`

## Requirements
- R1: After synchronous reset, every output valid is low, every input ready is low and the error flag is low.
- R2: The route field of a burst's first word selects the output port. Data and tail bits reach that output unchanged. Route fields of later words in the same burst are ignored.
- R3: Every word leaving an output carries, in its route field, the index of the input port it entered on.
- R4: An output that has accepted a non-tail word stays locked to that input until the input's tail word is accepted. Other inputs that request the output see ready low, even in cycles where the owner has no valid word.
- R5: Arbitration is round-robin per output. After a burst from input w ends, the search for the next winner starts at input w+1, wrapping to 0 after the last port.
- R6: In the cycle right after a tail word is accepted, the output can grant and pass the first word of a new burst, with no idle cycle in between.
- R7: While an output's ready is low, the input driving it sees ready low, and the output keeps showing the same word.
- R8: Bursts between disjoint input/output pairs move in the same cycle, and each input is granted by at most one output.
- R9: A first word whose route value is equal to or greater than the port count starts a discarded burst. Every word of it, up to and including its tail, is accepted with ready high and appears on no output. From the next cycle on, the error flag is high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORTS | Per-input word valid |
| in_ready | output | NPORTS | Per-input word accepted |
| in_data | input | NPORTS*DATA_W | Per-input data field |
| in_tail | input | NPORTS | Per-input tail flag (1 = last word of burst) |
| in_route | input | NPORTS*4 | Per-input route field; destination on the first word |
| out_valid | output | NPORTS | Per-output word valid |
| out_ready | input | NPORTS | Per-output receiver ready |
| out_data | output | NPORTS*DATA_W | Per-output data field |
| out_tail | output | NPORTS | Per-output tail flag |
| out_route | output | NPORTS*4 | Per-output source port index |
| err_flag | output | 1 | Sticky flag: a burst with an invalid destination was seen |

## Verification
The bench drives contention for one output while the owner pauses between words. This is aimed at an arbiter that frees the output on an idle cycle instead of on the tail, which would let a second input cut into the burst. The bench then releases the tail while both inputs request again. This exposes a pointer that fails to skip past the last winner, which would starve the waiting input, and a grant that waits one extra cycle. A stalled receiver must hold the word and keep the sender waiting; a design that drops the ready coupling would lose a word. A burst aimed at port index equal to the port count, followed by a later word whose route field is valid, checks that the whole discarded burst stays off the outputs and that the error flag is set and stays set.

// File: rtl/burst_xbar_pkg.sv
package burst_xbar_pkg;

    localparam int ROUTE_W = 4;

    typedef enum logic {
        ARB_OPEN,
        ARB_HELD
    } arb_state_e;

    typedef struct packed {
        logic               in_burst;
        logic               discard;
        logic [ROUTE_W-1:0] dest;
    } ing_state_t;

    function automatic int rr_after(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/bxb_ingress.sv
module bxb_ingress
    import burst_xbar_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic               tail,
    input  logic [ROUTE_W-1:0] route,
    input  logic               accept,
    output logic [ROUTE_W-1:0] dest,
    output logic               req,
    output logic               bad_start,
    output logic               discard_now
);
    localparam logic [ROUTE_W:0] PORT_LIMIT = (ROUTE_W + 1)'(NPORTS);

    ing_state_t st;

    always_comb begin
        dest        = st.in_burst ? st.dest : route;
        bad_start   = valid && !st.in_burst && ({1'b0, route} >= PORT_LIMIT);
        discard_now = st.discard || bad_start;
        req         = valid && !discard_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (accept) begin
            if (tail) begin
                st.in_burst <= 1'b0;
                st.discard  <= 1'b0;
            end else begin
                st.in_burst <= 1'b1;
                st.discard  <= discard_now;
                st.dest     <= dest;
            end
        end
    end

    // R9: a discarded burst keeps discarding until its tail is taken
    a_r9_discard_holds: assert property (@(posedge clk) disable iff (rst)
        (st.discard && !(accept && tail)) |=> st.discard);

    // R2: the destination latched for a burst does not move while it waits
    a_r2_dest_stable: assert property (@(posedge clk) disable iff (rst)
        (st.in_burst && !accept) |=> $stable(st.dest));

endmodule

// File: rtl/bxb_arbiter.sv
module bxb_arbiter
    import burst_xbar_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] req,
    input  logic [NPORTS-1:0] tails,
    input  logic              out_ready,
    output logic [IW-1:0]     sel,
    output logic              sel_vld
);
    arb_state_e    st;
    logic [IW-1:0] owner;
    logic [IW-1:0] ptr;
    logic [IW-1:0] pick;
    logic          found;
    logic          fire;
    logic          last;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NPORTS; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NPORTS) idx = idx - NPORTS;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
        sel     = (st == ARB_HELD) ? owner : pick;
        sel_vld = (st == ARB_HELD) ? req[owner] : found;
        fire    = sel_vld && out_ready;
        last    = fire && tails[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ARB_OPEN;
            owner <= '0;
            ptr   <= '0;
        end else if (fire) begin
            if (last) begin
                st  <= ARB_OPEN;
                ptr <= IW'(rr_after(int'(sel), NPORTS));
            end else begin
                st    <= ARB_HELD;
                owner <= sel;
            end
        end
    end

    // R4: the owner keeps the output until its tail is accepted
    a_r4_owner_held: assert property (@(posedge clk) disable iff (rst)
        (st == ARB_HELD && !last) |=> (st == ARB_HELD && $stable(owner)));

    // R6: the output is open again right after a tail word
    a_r6_open_after_tail: assert property (@(posedge clk) disable iff (rst)
        last |=> (st == ARB_OPEN));

    // R5: the priority pointer moves only when a burst ends
    a_r5_ptr_still: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(ptr));

endmodule

// File: rtl/burst_xbar.sv
module burst_xbar
    import burst_xbar_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int DATA_W = 36
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORTS-1:0]          in_valid,
    output logic [NPORTS-1:0]          in_ready,
    input  logic [NPORTS*DATA_W-1:0]   in_data,
    input  logic [NPORTS-1:0]          in_tail,
    input  logic [NPORTS*ROUTE_W-1:0]  in_route,
    output logic [NPORTS-1:0]          out_valid,
    input  logic [NPORTS-1:0]          out_ready,
    output logic [NPORTS*DATA_W-1:0]   out_data,
    output logic [NPORTS-1:0]          out_tail,
    output logic [NPORTS*ROUTE_W-1:0]  out_route,
    output logic                       err_flag
);
    localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic [ROUTE_W-1:0] dest    [NPORTS];
    logic [NPORTS-1:0]  req_in;
    logic [NPORTS-1:0]  bad;
    logic [NPORTS-1:0]  disc;
    logic [NPORTS-1:0]  accept;
    logic [NPORTS-1:0]  req_m   [NPORTS];
    logic [NPORTS-1:0]  grant_m [NPORTS];
    logic [IW-1:0]      sel     [NPORTS];
    logic [NPORTS-1:0]  sel_vld;

    assign accept = in_valid & in_ready;

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_in
        bxb_ingress #(.NPORTS(NPORTS)) u_ing (
            .clk        (clk),
            .rst        (rst),
            .valid      (in_valid[gi]),
            .tail       (in_tail[gi]),
            .route      (in_route[gi*ROUTE_W +: ROUTE_W]),
            .accept     (accept[gi]),
            .dest       (dest[gi]),
            .req        (req_in[gi]),
            .bad_start  (bad[gi]),
            .discard_now(disc[gi])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            for (int i = 0; i < NPORTS; i++) begin
                req_m[o][i] = req_in[i] && (dest[i] == ROUTE_W'(o));
            end
        end
    end

    for (genvar go = 0; go < NPORTS; go++) begin : g_out
        bxb_arbiter #(.NPORTS(NPORTS), .IW(IW)) u_arb (
            .clk      (clk),
            .rst      (rst),
            .req      (req_m[go]),
            .tails    (in_tail),
            .out_ready(out_ready[go]),
            .sel      (sel[go]),
            .sel_vld  (sel_vld[go])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            out_valid[o]                     = sel_vld[o];
            out_data[o*DATA_W +: DATA_W]     = in_data[int'(sel[o])*DATA_W +: DATA_W];
            out_tail[o]                      = in_tail[sel[o]];
            out_route[o*ROUTE_W +: ROUTE_W]  = ROUTE_W'(sel[o]);
        end
    end

    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            in_ready[i] = disc[i];
            for (int o = 0; o < NPORTS; o++) begin
                grant_m[i][o] = req_m[o][i] && sel_vld[o] && (int'(sel[o]) == i);
                if (grant_m[i][o] && out_ready[o]) in_ready[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       err_flag <= 1'b0;
        else if (|bad) err_flag <= 1'b1;
    end

    // R9: the error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    for (genvar gc = 0; gc < NPORTS; gc++) begin : g_chk
        // R8: no input is granted by two outputs at once
        a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant_m[gc]));
        // R3: a valid output word names an input that is presenting a word
        a_r3_source_valid: assert property (@(posedge clk) disable iff (rst)
            out_valid[gc] |-> in_valid[out_route[gc*ROUTE_W +: ROUTE_W]]);
    end

endmodule

// File: tb/burst_xbar_bench.sv
module burst_xbar_bench;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int RW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      in_valid;
    logic [N-1:0]      in_ready;
    logic [N*DW-1:0]   in_data;
    logic [N-1:0]      in_tail;
    logic [N*RW-1:0]   in_route;
    logic [N-1:0]      out_valid;
    logic [N-1:0]      out_ready;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      out_tail;
    logic [N*RW-1:0]   out_route;
    logic              err_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    burst_xbar #(.NPORTS(N), .DATA_W(DW)) u_burst_xbar (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_tail(in_tail), .in_route(in_route),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tail(out_tail), .out_route(out_route), .err_flag(err_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int i, input bit v, input int rt, input bit t, input int d);
        in_valid[i]            = v;
        in_route[i*RW +: RW]   = rt[RW-1:0];
        in_tail[i]             = t;
        in_data[i*DW +: DW]    = d[DW-1:0];
    endtask

    task automatic idle_all();
        in_valid  = '0;
        in_tail   = '0;
        in_route  = '0;
        in_data   = '0;
        out_ready = '1;
    endtask

    function automatic int od(input int o);  return int'(out_data[o*DW +: DW]);   endfunction
    function automatic int orr(input int o); return int'(out_route[o*RW +: RW]);  endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        #1;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 0);
        check("R1 err_flag", int'(err_flag), 0);
        @(negedge clk);
    endtask

    task automatic t_route();
        idle_all();
        put(1, 1, 2, 1, 8'hA5);
        #1;
        check("R2 valid at out2", int'(out_valid), 4);
        check("R2 data", od(2), 8'hA5);
        check("R2 tail", int'(out_tail[2]), 1);
        check("R3 source route", orr(2), 1);
        check("R2 in_ready", int'(in_ready[1]), 1);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_lock_rr();
        idle_all();
        put(0, 1, 3, 0, 11);
        put(2, 1, 3, 1, 22);
        #1;
        check("R5 first winner", orr(3), 0);
        check("R2 first data", od(3), 11);
        check("R4 loser ready", int'(in_ready[2]), 0);
        @(negedge clk);
        put(0, 0, 0, 0, 0);
        #1;
        check("R4 owner gap valid", int'(out_valid[3]), 0);
        check("R4 gap loser ready", int'(in_ready[2]), 0);
        @(negedge clk);
        put(0, 1, 0, 0, 12);
        #1;
        check("R2 later route ignored", int'(out_valid[3]), 1);
        check("R4 owner continues", od(3), 12);
        check("R4 loser still waits", int'(in_ready[2]), 0);
        @(negedge clk);
        put(0, 1, 1, 1, 13);
        #1;
        check("R4 tail data", od(3), 13);
        check("R4 tail flag", int'(out_tail[3]), 1);
        @(negedge clk);
        put(0, 1, 3, 1, 14);
        #1;
        check("R6 R5 next winner", orr(3), 2);
        check("R6 no bubble data", od(3), 22);
        check("R5 input0 waits", int'(in_ready[0]), 0);
        @(negedge clk);
        put(2, 0, 0, 0, 0);
        #1;
        check("R5 input0 served", orr(3), 0);
        check("R5 input0 data", od(3), 14);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_backpressure();
        idle_all();
        out_ready[0] = 1'b0;
        put(1, 1, 0, 1, 33);
        #1;
        check("R7 valid held", int'(out_valid[0]), 1);
        check("R7 sender stalled", int'(in_ready[1]), 0);
        @(negedge clk);
        #1;
        check("R7 word kept", od(0), 33);
        check("R7 still stalled", int'(in_ready[1]), 0);
        @(negedge clk);
        out_ready[0] = 1'b1;
        #1;
        check("R7 released", int'(in_ready[1]), 1);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_parallel();
        idle_all();
        put(0, 1, 1, 1, 41);
        put(1, 1, 0, 1, 42);
        put(3, 1, 2, 1, 43);
        #1;
        check("R8 out1 data", od(1), 41);
        check("R8 out0 data", od(0), 42);
        check("R8 out2 data", od(2), 43);
        check("R8 R3 out2 route", orr(2), 3);
        check("R8 all ready", int'(in_ready), 4'b1011);
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_drop();
        idle_all();
        #1;
        check("R9 err before", int'(err_flag), 0);
        put(3, 1, 4, 0, 51);
        #1;
        check("R9 bad first taken", int'(in_ready[3]), 1);
        check("R9 bad first hidden", int'(out_valid), 0);
        @(negedge clk);
        #1;
        check("R9 err set", int'(err_flag), 1);
        put(3, 1, 1, 1, 52);
        #1;
        check("R9 bad tail taken", int'(in_ready[3]), 1);
        check("R9 bad tail hidden", int'(out_valid), 0);
        @(negedge clk);
        put(3, 1, 1, 1, 53);
        #1;
        check("R9 next burst valid", int'(out_valid), 2);
        check("R9 next burst data", od(1), 53);
        @(negedge clk);
        idle_all();
        #1;
        check("R9 err stays", int'(err_flag), 1);
    endtask

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_route();
        t_lock_rr();
        t_backpressure();
        t_parallel();
        t_drop();
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            finish_run();
        end
    end

endmodule